// File: doc/BRIEF.md
# Warning-Driven Forward-Bias Level Controller

This block converts timing-margin warnings from a set of canary flip-flops into a discrete forward-bias setting for the gates on a circuit's critical paths. The individual warning bits are merged into a single warning. While the offline self-test runs, each accepted warning raises a small level counter by one step. The counter only moves upward, because aging only degrades the circuit. It stops at the strongest bias level and stays there until the next reset.

The counter value drives a one-hot set of enables, with one line for each bias option. The analog bias circuitry uses these lines directly. Each accepted warning also produces a single-cycle stall request for the test-pattern sequencer. That cycle gives the new bias time to settle before it is judged again. During the stall cycle the controller ignores warnings. A flag reports when the bias range is used up.

Top module: `bias_level_ctrl`

## Requirements
- R1: The warning used by the controller is the OR of all `warn_in` bits. A warning on any single bit alone counts as a warning.
- R2: Reset is synchronous and active low. While `rst_n` is 0 at a rising clock edge, `level` becomes 0, `bias_en` becomes 4'b0001, and `stall_req` and `bias_max` become 0.
- R3: An accepted warning takes effect at the next rising edge. At that edge `level` rises by exactly one. A warning is accepted when `test_active` is 1, at least one warning bit is 1, `stall_req` is 0 and `level` is below 3.
- R4: `level` saturates at 3 (binary 11). Further warnings leave it at 3 and it never wraps to 0.
- R5: While reset is not applied, `level` never decreases.
- R6: `bias_en` is one-hot. Bit i is 1 exactly when `level` equals i. Bit 0 means no bias, and bits 1 to 3 select increasing forward bias.
- R7: Warnings sampled while `test_active` is 0 have no effect on `level` or `stall_req`.
- R8: In the cycle in which `stall_req` is 1, a warning is ignored. The level therefore changes at most once every two cycles.
- R9: `stall_req` is 1 for exactly the one cycle after each accepted warning. It does not pulse for warnings that arrive while `level` is 3.
- R10: `bias_max` is 1 exactly when `level` is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on/preset path) |
| test_active | input | 1 | Offline test in progress; warnings count only while high |
| warn_in | input | WARN_N (4) | Warning bits from the canary flip-flops |
| level | output | LEVEL_W (2) | Current bias level, 0 = no bias |
| bias_en | output | 2**LEVEL_W (4) | One-hot enable for each bias option |
| stall_req | output | 1 | One-cycle stall request to the pattern sequencer |
| bias_max | output | 1 | Bias range exhausted (level at top) |

## Verification
The inputs for a cycle are settled before a rising edge. `level` and `stall_req` are registered, so they reflect that cycle's warning one edge later. `bias_en` and `bias_max` are decoded from `level` with no further register, so they follow it in the same cycle. The bench drives inputs on the falling edge. At each rising edge it updates its reference model, then compares all four outputs 1 ns after that edge. This means every result is checked in the cycle in which it is due. The hold-off window in the model is counted from `stall_req` itself, so back-to-back warnings are expected to step the level only every second cycle.

// File: rtl/bias_ctrl_pkg.sv
// Package: shared defaults for the bias level controller.
// Assumes: level codes are binary, 0 = no bias, increasing code = more forward bias.
package bias_ctrl_pkg;
    parameter int unsigned DEF_WARN_N  = 4;
    parameter int unsigned DEF_LEVEL_W = 2;
endpackage

// File: rtl/warn_merge.sv
// Module: warn_merge
// Merges the warning bits of all canary flip-flops into one warning.
// Assumes: warning bits are already synchronous to clk.
module warn_merge #(
    parameter int unsigned WARN_N = 4
) (
    input  logic [WARN_N-1:0] warn_bits,
    output logic              warn_any
);
    // Purpose: reduction OR of every warning source.
    always_comb begin
        warn_any = |warn_bits;
    end
endmodule

// File: rtl/bias_step_counter.sv
// Module: bias_step_counter
// Up-only saturating level counter. It steps once per accepted warning and
// asserts a one-cycle stall after each step. During that stall cycle it ignores warnings.
// Assumes: synchronous active-low reset; warnings only count during test.
module bias_step_counter #(
    parameter int unsigned LEVEL_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               test_active,
    input  logic               warn_any,
    output logic [LEVEL_W-1:0] level,
    output logic               stall_req,
    output logic               at_max
);
    localparam logic [LEVEL_W-1:0] TOP_LEVEL = {LEVEL_W{1'b1}};

    logic accept;

    // Purpose: flag the top level so no further steps are taken.
    always_comb begin
        at_max = (level == TOP_LEVEL);
    end

    // Purpose: decide whether this cycle's warning is taken.
    always_comb begin
        accept = test_active && warn_any && !stall_req && !at_max;
    end

    // Purpose: step the level and raise the one-cycle stall on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level     <= '0;
            stall_req <= 1'b0;
        end else begin
            stall_req <= accept;
            if (accept) begin
                level <= level + LEVEL_W'(1);
            end
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (level == TOP_LEVEL) |=> (level == TOP_LEVEL)); // R4
    AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (level >= $past(level))); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !test_active |=> ($stable(level) && !stall_req)); // R7
    AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> $stable(level)); // R8
    AST_STALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> !stall_req); // R9
endmodule

// File: rtl/level_onehot_dec.sv
// Module: level_onehot_dec
// Binary-to-one-hot decoder that turns the level code into bias option enables.
// Assumes: code is always a valid level, so exactly one output is high.
module level_onehot_dec #(
    parameter int unsigned LEVEL_W = 2,
    localparam int unsigned OPT_N  = 1 << LEVEL_W
) (
    input  logic [LEVEL_W-1:0] code,
    output logic [OPT_N-1:0]   enables
);
    // Purpose: one comparator per bias option.
    for (genvar g = 0; g < OPT_N; g++) begin : g_opt
        assign enables[g] = (code == LEVEL_W'(g));
    end

    always_comb begin
        AST_ONEHOT_EN: assert ($countones(enables) == 1 || $isunknown(code)); // R6
    end
endmodule

// File: rtl/bias_level_ctrl.sv
// Module: bias_level_ctrl (top)
// Merges the canary warnings, keeps the up-only bias level and decodes it
// into one-hot bias option enables. It also raises a stall for the pattern sequencer.
// Assumes: rst_n is driven by the power-on/preset path and is synchronous to clk.
module bias_level_ctrl
    import bias_ctrl_pkg::*;
#(
    parameter int unsigned WARN_N  = DEF_WARN_N,
    parameter int unsigned LEVEL_W = DEF_LEVEL_W,
    localparam int unsigned OPT_N  = 1 << LEVEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               test_active,
    input  logic [WARN_N-1:0]  warn_in,
    output logic [LEVEL_W-1:0] level,
    output logic [OPT_N-1:0]   bias_en,
    output logic               stall_req,
    output logic               bias_max
);
    logic warn_any;

    warn_merge #(.WARN_N(WARN_N)) u_merge (
        .warn_bits (warn_in),
        .warn_any  (warn_any)
    );

    bias_step_counter #(.LEVEL_W(LEVEL_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_active (test_active),
        .warn_any    (warn_any),
        .level       (level),
        .stall_req   (stall_req),
        .at_max      (bias_max)
    );

    level_onehot_dec #(.LEVEL_W(LEVEL_W)) u_dec (
        .code    (level),
        .enables (bias_en)
    );

    AST_MAX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        bias_max == bias_en[OPT_N-1]); // R10
    AST_ANY_BIT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active && (warn_in != '0) && !stall_req && !bias_max) |=> stall_req); // R1
endmodule

// File: tb/tb_bias_level_ctrl.sv
// Bench: directed corner cases plus seeded random stimulus. Each output is
// checked against a reference model computed by bench functions.
module tb_bias_level_ctrl;
    localparam int WN = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          test_active;
    logic [WN-1:0] warn_in;
    logic [1:0]    level;
    logic [3:0]    bias_en;
    logic          stall_req;
    logic          bias_max;

    int vectors = 0;
    int errors  = 0;
    logic [1:0] m_lvl;
    logic       m_stall;

    always #2 clk = ~clk; // 250 MHz

    bias_level_ctrl dut (
        .clk(clk), .rst_n(rst_n), .test_active(test_active), .warn_in(warn_in),
        .level(level), .bias_en(bias_en), .stall_req(stall_req), .bias_max(bias_max)
    );

    function automatic logic [3:0] exp_onehot(input logic [1:0] l);
        return 4'b0001 << l;
    endfunction

    function automatic logic exp_accept(input logic ta, input logic [WN-1:0] w,
                                        input logic st, input logic [1:0] l);
        return ta && (w != '0) && !st && (l != 2'd3);
    endfunction

    task automatic check(input string tag);
        vectors++;
        if (level !== m_lvl || stall_req !== m_stall ||
            bias_en !== exp_onehot(m_lvl) || bias_max !== (m_lvl == 2'd3)) begin
            errors++;
            $display("FAIL %s: got lvl=%0d en=%b stall=%b max=%b exp lvl=%0d en=%b stall=%b max=%b",
                     tag, level, bias_en, stall_req, bias_max,
                     m_lvl, exp_onehot(m_lvl), m_stall, (m_lvl == 2'd3));
        end
    endtask

    // Drive one cycle at negedge, update the model at posedge, and check 1 ns later.
    task automatic cyc(input logic r, input logic ta, input logic [WN-1:0] w, input string tag);
        @(negedge clk);
        rst_n = r; test_active = ta; warn_in = w;
        @(posedge clk);
        if (!r) begin
            m_lvl = 2'd0; m_stall = 1'b0;
        end else begin
            logic acc;
            acc = exp_accept(ta, w, m_stall, m_lvl);
            m_stall = acc;
            if (acc) m_lvl = m_lvl + 2'd1;
        end
        #1;
        check(tag);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        m_lvl = 2'd0; m_stall = 1'b0;
        rst_n = 1'b0; test_active = 1'b0; warn_in = '0;
        cyc(1'b0, 1'b0, '0, "R2 reset");
        cyc(1'b0, 1'b1, 4'hF, "R2 reset dominates warning");
        // R7: warnings outside test are ignored
        cyc(1'b1, 1'b0, 4'hF, "R7 idle warning");
        cyc(1'b1, 1'b0, 4'h1, "R7 idle warning");
        // R1: each single bit steps the level; R8 hold-off cycle in between
        for (int b = 0; b < 3; b++) begin
            cyc(1'b1, 1'b1, WN'(1) << b, "R1/R3 single bit step");
            cyc(1'b1, 1'b1, 4'hF, "R8 hold-off during stall");
        end
        // R4/R9/R10: saturated, no stall and no wrap
        cyc(1'b1, 1'b1, 4'h8, "R4/R9 saturated no step");
        cyc(1'b1, 1'b1, 4'hF, "R4/R10 stays at top");
        cyc(1'b1, 1'b0, 4'h0, "R5/R6 level held");
        cyc(1'b0, 1'b0, 4'h0, "R2 reset from top");
        // R1: top bit alone
        cyc(1'b1, 1'b1, 4'h8, "R1 top bit");
        cyc(1'b1, 1'b1, 4'h0, "R9 stall pulse ends");
        // random phase
        seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < 3000; i++) begin
            logic r, ta;
            logic [WN-1:0] w;
            r  = ($urandom % 64) != 0;
            ta = ($urandom % 4) != 0;
            w  = (($urandom % 3) == 0) ? WN'($urandom) : '0;
            cyc(r, ta, w, "R3/R5/R6/R8/R9 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule